// File: doc/BRIEF.md
# Banked internal data memory decoder

This block is the on-chip data space of a small 8-bit controller. It holds 256 bytes of internal RAM and four special function registers: the accumulator, the B register, the status word and the stack pointer. A single port serves every access. The caller gives an address, a 2-bit access-mode code, read and write strobes and write data. The block works out which storage the access reaches and returns the byte or bit that was read.

One address can land in different places. The result depends on the mode. Direct bytes at 0x80 and above are special function registers, while indirect bytes there are a separate upper RAM. Working-register numbers move with the register bank held in the status word. Bit addresses fold onto bytes of both low RAM and the SFR space.

Reads are combinational from the current inputs. Writes take effect on the rising clock edge. A bit write reads the target byte and writes it back in the same cycle with one bit replaced.

Top module: `idata_space`

## Requirements
- R1: In direct mode (code 0) and indirect mode (code 1), addresses 0x00 to 0x7F reach the same low RAM byte. A value written through one mode reads back through the other.
- R2: Indirect accesses to 0x80 to 0xFF reach a separate 128-byte upper RAM. No direct access reads or writes that RAM, and indirect reads never return an SFR value.
- R3: Direct accesses to 0x80 to 0xFF reach the SFRs. The accumulator is at 0xE0, B at 0xF0, the status word at 0xD0 and the stack pointer at 0x81.
- R4: In register mode (code 2), addr[2:0] is the register number n. The access reaches low RAM byte 8*bank+n, where bank is bits 4:3 of the status word.
- R5: In bit mode (code 3), bit addresses 0x00 to 0x7F select bit (addr mod 8) of RAM byte 0x20+addr/8. A bit read returns the bit in rdata[0], with rdata[7:1] zero.
- R6: In bit mode, bit addresses 0x80 to 0xFF select bit (addr mod 8) of the SFR byte at (addr AND 0xF8).
- R7: A bit write stores wdata[0] into the addressed bit only, leaves the other seven bits unchanged, and is visible to a read in the next cycle.
- R8: Changing the register bank does not change the accumulator.
- R9: A direct read of an unimplemented SFR address returns 0x00, and a write to one, by byte or by bit, changes nothing.
- R10: A write to the status word changes the bank used by register accesses from the next cycle on.
- R11: A synchronous active-low reset clears all RAM, the accumulator, B and the status word, and sets the stack pointer to 0x07.
- R12: rdata is 0x00 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_mode | input | 2 | Access mode: 0 direct, 1 indirect, 2 register, 3 bit |
| addr | input | 8 | Byte address, register number or bit address |
| rd_en | input | 1 | Read strobe; gates rdata |
| wr_en | input | 1 | Write strobe; applied at the clock edge |
| wdata | input | 8 | Write byte; bit writes use wdata[0] |
| rdata | output | 8 | Read byte, or the read bit in bit 0 |

## Verification
The assertions assume that acc_mode, addr and wdata are stable across each rising edge while wr_en is high. They also assume that any write to the status word is made in direct mode or bit mode, which are the only paths the address decode offers to it. The stimulus changes every input only on the falling clock edge and holds one access per cycle. Mode switches and bank changes are made between accesses and never inside one, so each check sees a single settled decode.

// File: rtl/idata_pkg.sv
// Package: shared types and fixed addresses of the internal data space.
// Assumes an 8-bit address space with the SFR map held at fixed locations.
package idata_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_REG      = 2'd2,
        AM_BIT      = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        TG_NONE = 2'd0,
        TG_RAM  = 2'd1,
        TG_SFR  = 2'd2
    } target_e;

    localparam logic [7:0] SFR_ACC      = 8'hE0;
    localparam logic [7:0] SFR_B        = 8'hF0;
    localparam logic [7:0] SFR_STATUS   = 8'hD0;
    localparam logic [7:0] SFR_STACK    = 8'h81;
    localparam logic [7:0] STACK_RESET  = 8'h07;
    localparam logic [7:0] BIT_RAM_BASE = 8'h20;
    localparam int         BANK_LSB     = 3;

endpackage

// File: rtl/idata_resolve.sv
// Module: idata_resolve
// Maps an (access mode, address, bank) triple to a storage target, a byte
// index within that target and a bit position. Purely combinational.
// Assumes AW is 8 so that the upper address bit splits each half.
module idata_resolve
    import idata_pkg::*;
#(
    parameter int AW     = 8,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3
) (
    input  amode_e         mode,
    input  logic [AW-1:0]  addr,
    input  logic [BANK_W-1:0] bank,
    output target_e        tgt,
    output logic [AW-1:0]  idx,
    output logic [2:0]     bitpos
);
    localparam int PAD_W = AW - BANK_W - REG_W;

    // Decode the target and index for the current access mode.
    always_comb begin
        tgt    = TG_NONE;
        idx    = addr;
        bitpos = addr[2:0];
        unique case (mode)
            AM_DIRECT: begin
                tgt = addr[AW-1] ? TG_SFR : TG_RAM;
                idx = addr;
            end
            AM_INDIRECT: begin
                tgt = TG_RAM;
                idx = addr;
            end
            AM_REG: begin
                tgt = TG_RAM;
                idx = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
            end
            AM_BIT: begin
                if (addr[AW-1]) begin
                    tgt = TG_SFR;
                    idx = {addr[AW-1:3], 3'b000};
                end else begin
                    tgt = TG_RAM;
                    idx = BIT_RAM_BASE + AW'(addr[AW-2:3]);
                end
            end
            default: tgt = TG_NONE;
        endcase
    end

    // R2: a direct access must never land in upper RAM.
    always_comb begin
        a_r2_direct_no_upper: assert (!(mode == AM_DIRECT && tgt == TG_RAM && idx[AW-1]));
    end

endmodule

// File: rtl/idata_ram.sv
// Module: idata_ram
// 2^AW bytes of flop storage with one combinational read and one synchronous
// write on the same index. Assumes the index is stable around the clock edge.
module idata_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wbyte,
    output logic [DW-1:0] rbyte
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the write byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wbyte;
        end
    end

    // Combinational read of the addressed byte.
    always_comb rbyte = mem[idx];

    // R7: a write is present in storage on the next cycle.
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wbyte)));

endmodule

// File: rtl/idata_sfr.sv
// Module: idata_sfr
// The implemented special function registers: accumulator, B, status word
// and stack pointer. Unimplemented addresses read zero and drop writes.
// Exports the register bank field of the status word.
module idata_sfr
    import idata_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DW-1:0]     wbyte,
    output logic [DW-1:0]     rbyte,
    output logic [BANK_W-1:0] bank
);
    logic [DW-1:0] acc_q, b_q, status_q, stack_q;

    // Register update on write or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            b_q      <= '0;
            status_q <= '0;
            stack_q  <= DW'(STACK_RESET);
        end else if (we) begin
            unique case (idx)
                SFR_ACC:    acc_q    <= wbyte;
                SFR_B:      b_q      <= wbyte;
                SFR_STATUS: status_q <= wbyte;
                SFR_STACK:  stack_q  <= wbyte;
                default:    ;
            endcase
        end
    end

    // Read mux; unknown addresses return zero.
    always_comb begin
        unique case (idx)
            SFR_ACC:    rbyte = acc_q;
            SFR_B:      rbyte = b_q;
            SFR_STATUS: rbyte = status_q;
            SFR_STACK:  rbyte = stack_q;
            default:    rbyte = '0;
        endcase
    end

    // Bank field taken from the status word.
    always_comb bank = status_q[BANK_LSB +: BANK_W];

    // R8: rewriting the status word leaves the accumulator alone.
    a_r8_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == SFR_STATUS) |=> (acc_q == $past(acc_q)));

    // R10: the bank follows a status write on the next cycle.
    a_r10_bank_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == SFR_STATUS) |=> (bank == $past(wbyte[BANK_LSB +: BANK_W])));

endmodule

// File: rtl/idata_space.sv
// Module: idata_space (top)
// Internal data space: routes each access through the resolver to low or
// upper RAM or to the SFR file, builds bit reads and bit read-modify-write.
// Assumes inputs settle before the rising edge and one access per cycle.
module idata_space
    import idata_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int BANK_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    acc_mode,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    amode_e            mode;
    target_e           tgt;
    logic [AW-1:0]     idx;
    logic [2:0]        bitpos;
    logic [BANK_W-1:0] bank;
    logic [DW-1:0]     ram_rd, sfr_rd, byte_rd, merged, wbyte;
    logic              ram_we, sfr_we;

    always_comb mode = amode_e'(acc_mode);

    idata_resolve #(.AW(AW), .BANK_W(BANK_W), .REG_W(3)) u_resolve (
        .mode(mode), .addr(addr), .bank(bank),
        .tgt(tgt), .idx(idx), .bitpos(bitpos)
    );

    idata_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(idx),
        .wbyte(wbyte), .rbyte(ram_rd)
    );

    idata_sfr #(.AW(AW), .DW(DW), .BANK_W(BANK_W)) u_sfr (
        .clk(clk), .rst_n(rst_n), .we(sfr_we), .idx(idx),
        .wbyte(wbyte), .rbyte(sfr_rd), .bank(bank)
    );

    // Select the byte from the resolved target.
    always_comb begin
        unique case (tgt)
            TG_RAM:  byte_rd = ram_rd;
            TG_SFR:  byte_rd = sfr_rd;
            default: byte_rd = '0;
        endcase
    end

    // Merge the new bit into the current byte for bit writes.
    always_comb begin
        merged         = byte_rd;
        merged[bitpos] = wdata[0];
        wbyte          = (mode == AM_BIT) ? merged : wdata;
    end

    // Steer the write strobe to one storage.
    always_comb begin
        ram_we = wr_en && (tgt == TG_RAM);
        sfr_we = wr_en && (tgt == TG_SFR);
    end

    // Shape the read result for byte or bit access, gated by rd_en.
    always_comb begin
        if (!rd_en)              rdata = '0;
        else if (mode == AM_BIT) rdata = {{(DW-1){1'b0}}, byte_rd[bitpos]};
        else                     rdata = byte_rd;
    end

    // R7: a bit write differs from the old byte in at most one bit.
    always_comb begin
        if (wr_en && mode == AM_BIT)
            a_r7_single_bit: assert ($countones(merged ^ byte_rd) <= 1);
    end

    // R5: bit reads carry nothing above bit 0.
    a_r5_bit_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == AM_BIT) |-> (rdata[DW-1:1] == '0));

    // R2: writes never go to two storages at once.
    a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && sfr_we));

endmodule

// File: tb/sim_idata_space.sv
// Bench for idata_space: a vector table walked once, then directed reset checks.
module sim_idata_space;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_mode = 2'd0;
    logic [7:0] addr = 8'h00;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    idata_space u0 (
        .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    // Vector fields: {req[3:0], mode[1:0], wr, rd, addr[7:0], wdata[7:0], expect[7:0]}
    localparam int NV = 42;
    localparam logic [31:0] VEC [NV] = '{
        {4'd1,  2'd0, 1'b1, 1'b0, 8'h05, 8'h11, 8'h00},  // R1 direct write low RAM
        {4'd1,  2'd1, 1'b0, 1'b1, 8'h05, 8'h00, 8'h11},  // R1 indirect read same byte
        {4'd2,  2'd1, 1'b1, 1'b0, 8'h90, 8'hA5, 8'h00},  // R2 upper RAM write
        {4'd9,  2'd0, 1'b1, 1'b0, 8'h90, 8'h3C, 8'h00},  // R9 unimplemented SFR write
        {4'd2,  2'd1, 1'b0, 1'b1, 8'h90, 8'h00, 8'hA5},  // R2 upper RAM untouched
        {4'd9,  2'd0, 1'b0, 1'b1, 8'h90, 8'h00, 8'h00},  // R9 unimplemented reads zero
        {4'd3,  2'd0, 1'b1, 1'b0, 8'hE0, 8'h77, 8'h00},  // R3 accumulator write
        {4'd3,  2'd0, 1'b0, 1'b1, 8'hE0, 8'h00, 8'h77},  // R3 accumulator read
        {4'd2,  2'd1, 1'b0, 1'b1, 8'hE0, 8'h00, 8'h00},  // R2 indirect E0 is RAM
        {4'd3,  2'd0, 1'b1, 1'b0, 8'h81, 8'h30, 8'h00},  // R3 stack pointer write
        {4'd3,  2'd0, 1'b0, 1'b1, 8'h81, 8'h00, 8'h30},  // R3 stack pointer read
        {4'd4,  2'd2, 1'b1, 1'b0, 8'h04, 8'h44, 8'h00},  // R4 bank 0 R4 write
        {4'd10, 2'd0, 1'b1, 1'b0, 8'hD0, 8'h18, 8'h00},  // R10 select bank 3
        {4'd10, 2'd2, 1'b0, 1'b1, 8'h04, 8'h00, 8'h00},  // R10 R4 now at 0x1C
        {4'd4,  2'd2, 1'b1, 1'b0, 8'h04, 8'h99, 8'h00},  // R4 bank 3 R4 write
        {4'd4,  2'd0, 1'b0, 1'b1, 8'h1C, 8'h00, 8'h99},  // R4 lands at 0x1C
        {4'd8,  2'd0, 1'b0, 1'b1, 8'hE0, 8'h00, 8'h77},  // R8 accumulator unchanged
        {4'd4,  2'd0, 1'b0, 1'b1, 8'h04, 8'h00, 8'h44},  // R4 bank 0 byte kept
        {4'd5,  2'd0, 1'b1, 1'b0, 8'h21, 8'hF0, 8'h00},  // R5 seed bit-area byte
        {4'd7,  2'd3, 1'b1, 1'b0, 8'h0B, 8'h01, 8'h00},  // R7 set bit 3 of 0x21
        {4'd7,  2'd3, 1'b0, 1'b1, 8'h0B, 8'h00, 8'h01},  // R7 bit visible next cycle
        {4'd7,  2'd0, 1'b0, 1'b1, 8'h21, 8'h00, 8'hF8},  // R7 only bit 3 changed
        {4'd7,  2'd3, 1'b1, 1'b0, 8'h0C, 8'h00, 8'h00},  // R7 clear bit 4 of 0x21
        {4'd7,  2'd0, 1'b0, 1'b1, 8'h21, 8'h00, 8'hE8},  // R7 only bit 4 changed
        {4'd5,  2'd0, 1'b1, 1'b0, 8'h2F, 8'h80, 8'h00},  // R5 seed top bit byte
        {4'd5,  2'd3, 1'b0, 1'b1, 8'h7F, 8'h00, 8'h01},  // R5 bit 0x7F is 0x2F.7
        {4'd5,  2'd3, 1'b0, 1'b1, 8'h7E, 8'h00, 8'h00},  // R5 bit 0x7E is 0x2F.6
        {4'd6,  2'd3, 1'b1, 1'b0, 8'hE1, 8'h00, 8'h00},  // R6 clear accumulator bit 1
        {4'd6,  2'd0, 1'b0, 1'b1, 8'hE0, 8'h00, 8'h75},  // R6 accumulator 0x75
        {4'd6,  2'd3, 1'b0, 1'b1, 8'hD3, 8'h00, 8'h01},  // R6 status bit 3
        {4'd6,  2'd3, 1'b0, 1'b1, 8'hD5, 8'h00, 8'h00},  // R6 status bit 5
        {4'd10, 2'd3, 1'b1, 1'b0, 8'hD3, 8'h00, 8'h00},  // R10 bank 2 by bit write
        {4'd10, 2'd2, 1'b0, 1'b1, 8'h04, 8'h00, 8'h00},  // R10 R4 now at 0x14
        {4'd4,  2'd2, 1'b1, 1'b0, 8'h00, 8'h5A, 8'h00},  // R4 bank 2 R0 write
        {4'd4,  2'd0, 1'b0, 1'b1, 8'h10, 8'h00, 8'h5A},  // R4 lands at 0x10
        {4'd9,  2'd3, 1'b1, 1'b0, 8'h85, 8'h01, 8'h00},  // R9 bit write to empty SFR
        {4'd9,  2'd3, 1'b0, 1'b1, 8'h85, 8'h00, 8'h00},  // R9 bit still zero
        {4'd9,  2'd0, 1'b0, 1'b1, 8'h80, 8'h00, 8'h00},  // R9 byte still zero
        {4'd12, 2'd0, 1'b0, 1'b1, 8'hE0, 8'h00, 8'h00},  // R12 marker, rd cleared below
        {4'd3,  2'd0, 1'b1, 1'b0, 8'hF0, 8'hC3, 8'h00},  // R3 B register write
        {4'd6,  2'd3, 1'b0, 1'b1, 8'hF0, 8'h00, 8'h01},  // R6 B bit 0
        {4'd6,  2'd3, 1'b0, 1'b1, 8'hF2, 8'h00, 8'h00}   // R6 B bit 2
    };

    // Compare one observed byte against its expectation.
    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d actual %02h expected %02h", req, got, exp);
        end
    endtask

    // Apply one access on the falling edge and check a read shortly after.
    task automatic access(input int req, input logic [1:0] m, input logic w, input logic r,
                          input logic [7:0] a, input logic [7:0] d, input logic [7:0] exp);
        @(negedge clk);
        acc_mode = m; addr = a; wr_en = w; rd_en = r; wdata = d;
        #1;
        if (r || req == 12) check(req, rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: state just after reset.
        access(11, 2'd0, 1'b0, 1'b1, 8'h81, 8'h00, 8'h07);
        access(11, 2'd0, 1'b0, 1'b1, 8'hE0, 8'h00, 8'h00);
        access(11, 2'd1, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00);
        access(11, 2'd2, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            // R12: the marker entry reads with rd_en low.
            if (int'(v[31:28]) == 12)
                access(12, v[27:26], 1'b0, 1'b0, v[23:16], v[15:8], v[7:0]);
            else
                access(int'(v[31:28]), v[27:26], v[25], v[24], v[23:16], v[15:8], v[7:0]);
        end

        // R11: reset mid-run restores the initial state.
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(11, 2'd0, 1'b0, 1'b1, 8'h81, 8'h00, 8'h07);
        access(11, 2'd0, 1'b0, 1'b1, 8'h05, 8'h00, 8'h00);
        access(11, 2'd1, 1'b0, 1'b1, 8'h90, 8'h00, 8'h00);
        access(11, 2'd0, 1'b0, 1'b1, 8'hD0, 8'h00, 8'h00);

        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule